// File: doc/BRIEF.md
# Masked Pointer Data Fetcher Bank

The block holds a set of independent data fetchers. All of them read bytes from one shared, synchronously read memory that software fills once. Each fetcher keeps a 16-bit address pointer and an 8-bit window pair made of a mask and a compare value. The host sets these through a small register-write port.

When the host strobes a read of one fetcher, the block presents that fetcher's pointer to the memory. One clock later it returns either the stored byte or zero. The choice depends on a window test on the low pointer byte. After every read the pointer steps forward by one.

Object images can therefore stay resident in memory. Fetching only the rows inside a chosen window is enough to place a shape at a given position, with no reload of the data for each frame.

Top module: `fetch_bank`

## Requirements
- R1: After synchronous reset, every pointer, mask and compare register is zero and `rd_valid` is low, so a first read of any fetcher returns the memory byte at address 0x0000.
- R2: A register write targets the fetcher `wr_addr[AW-1:2]`. The field is chosen by `wr_addr[1:0]`: 0 is the pointer low byte, 1 is the pointer high byte, 2 is the mask and 3 is the compare value.
- R3: A read strobe (`rd_en` with `rd_sel`) yields `rd_valid` high on the next clock. If `((ptr[7:0] XOR compare) AND mask)` is zero, `rd_data` then equals the memory byte at the fetcher's pointer.
- R4: If that window expression is non-zero, `rd_data` is zero whatever the memory holds.
- R5: Every read advances the fetcher's pointer by one with 16-bit wraparound (0xFFFF becomes 0x0000), whether or not zero was returned.
- R6: Fetchers are independent: a read of one fetcher leaves every other pointer unchanged.
- R7: In the strobe cycle `mem_en` is high and `mem_addr` equals the selected fetcher's current pointer.
- R8: A pointer-byte write to the fetcher being read in the same cycle lets the read use the old pointer. The written byte lands, the other pointer byte keeps its old value, and the increment is discarded.
- R9: A mask or compare write that coincides with a read of the same fetcher does not affect that read, which is tested against the old window; the new value governs later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (5) | Fetcher index and field select |
| wr_data | input | 8 | Register write byte |
| rd_en | input | 1 | Data read strobe |
| rd_sel | input | IW (3) | Fetcher to read |
| rd_valid | output | 1 | Read result valid, one clock after the strobe |
| rd_data | output | 8 | Read result byte, or zero when outside the window |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, one clock after `mem_en` |

## Verification
The bench walks a pointer across both edges of a mask window. A design that tested the wrong pointer byte, or inverted the gate, returns data where zero is due or the reverse. Stepping a pointer through 0xFFFF catches a pointer that saturates or carries wrongly. Reading several fetchers in turn exposes an increment that leaks into a neighbour. Same-cycle write-and-read cases catch a design that lets the increment beat the host write, or that samples the window after the write instead of before.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [1:0] {
    FLD_PTR_LO = 2'd0,
    FLD_PTR_HI = 2'd1,
    FLD_MASK   = 2'd2,
    FLD_CMP    = 2'd3
  } fetch_field_e;
endpackage

// File: rtl/fetch_slot.sv
module fetch_slot
  import fetch_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  fetch_field_e      wr_field,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              adv,
  output logic [PTR_W-1:0]  ptr,
  output logic              in_window
);
  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] mask_q, cmp_q;
  logic              ptr_wr;

  assign ptr_wr = wr_hit && (wr_field == FLD_PTR_LO || wr_field == FLD_PTR_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      mask_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_hit) begin
        case (wr_field)
          FLD_PTR_LO: ptr_q[BYTE_W-1:0]     <= wr_data;
          FLD_PTR_HI: ptr_q[PTR_W-1:BYTE_W] <= wr_data;
          FLD_MASK:   mask_q                <= wr_data;
          FLD_CMP:    cmp_q                 <= wr_data;
          default:    ;
        endcase
      end
      // host pointer write wins over the read advance (R8)
      if (adv && !ptr_wr) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr       = ptr_q;
  assign in_window = ((ptr_q[BYTE_W-1:0] ^ cmp_q) & mask_q) == '0;

  // R5: a read with no pointer write steps the pointer by exactly one
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (adv && !ptr_wr) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

  // R2: low pointer byte takes the written value
  a_r2_ptr_lo: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_field == FLD_PTR_LO) |=> ptr_q[BYTE_W-1:0] == $past(wr_data));

  // R6: no read, no pointer write -> pointer holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ptr_wr) |=> $stable(ptr_q));
endmodule

// File: rtl/fetch_rd_stage.sv
module fetch_rd_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              win_pass,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  logic pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      pass_q   <= win_pass;
    end
  end

  // memory output is itself registered; only the gate sits after it
  assign rd_data = (rd_valid && pass_q) ? mem_rdata : '0;

  // R1: nothing valid in the first cycle after reset
  a_r1_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rd_valid);

  // R3: one-cycle read latency
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R4: a strobe outside the window yields zero
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !win_pass) |=> rd_data == '0);
endmodule

// File: rtl/fetch_bank.sv
module fetch_bank
  import fetch_pkg::*;
#(
  parameter int N_FETCH = 8,
  parameter int BYTE_W  = 8,
  localparam int IW     = (N_FETCH > 1) ? $clog2(N_FETCH) : 1,
  localparam int AW     = IW + 2,
  localparam int PTR_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_sel,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              mem_en,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic [PTR_W-1:0]   ptr_v [N_FETCH];
  logic [N_FETCH-1:0] pass_v;
  logic [N_FETCH-1:0] adv_v;
  logic [IW-1:0]      wr_idx;
  fetch_field_e       wr_field;

  assign wr_idx   = wr_addr[AW-1:2];
  assign wr_field = fetch_field_e'(wr_addr[1:0]);

  for (genvar g = 0; g < N_FETCH; g++) begin : g_slot
    assign adv_v[g] = rd_en && (rd_sel == IW'(g));
    fetch_slot #(.BYTE_W(BYTE_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (wr_en && (wr_idx == IW'(g))),
      .wr_field (wr_field),
      .wr_data  (wr_data),
      .adv      (adv_v[g]),
      .ptr      (ptr_v[g]),
      .in_window(pass_v[g])
    );
  end

  assign mem_en   = rd_en;
  assign mem_addr = ptr_v[rd_sel];

  fetch_rd_stage #(.BYTE_W(BYTE_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .win_pass (pass_v[rd_sel]),
    .mem_rdata(mem_rdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R6: at most one fetcher advances per cycle
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adv_v));

  // R7: consecutive strobes on one fetcher present consecutive addresses
  a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && $past(rd_en && !wr_en) && rd_sel == $past(rd_sel))
      |-> mem_addr == PTR_W'($past(mem_addr) + 1'b1));
endmodule

// File: tb/sim_fetch_bank.sv
module sim_fetch_bank;
  localparam int IW = 3;
  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [IW-1:0] rd_sel = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        mem_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_q = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fetch_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_q)
  );

  // memory content computed from the address; always odd, never zero
  function automatic logic [7:0] img(input logic [15:0] a);
    return (a[7:0] + 8'(3 * a[15:8])) | 8'h01;
  endfunction

  always @(posedge clk) if (mem_en) mem_q <= img(mem_addr);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input int idx, input int fld, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(idx * 4 + fld); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int idx, input logic [15:0] p, input logic [7:0] m, input logic [7:0] c);
    wreg(idx, 0, p[7:0]); wreg(idx, 1, p[15:8]); wreg(idx, 2, m); wreg(idx, 3, c);
  endtask

  task automatic rd(input int idx, output logic [7:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = IW'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    check("R1 valid low", 16'(rd_valid), 16'h0);
    rd(6, d, v);
    check("R1 first read", 16'(d), 16'(img(16'h0000)));
    check("R3 valid", 16'(v), 16'h1);
  endtask

  task automatic t_window();
    logic [7:0] d; logic v;
    setup(1, 16'h122F, 8'hF0, 8'h30);
    rd(1, d, v); check("R4 below window", 16'(d), 16'h0);
    check("R3 valid on gated read", 16'(v), 16'h1);
    rd(1, d, v); check("R3 window start", 16'(d), 16'(img(16'h1230)));
    setup(1, 16'h123F, 8'hF0, 8'h30);
    rd(1, d, v); check("R3 window end", 16'(d), 16'(img(16'h123F)));
    rd(1, d, v); check("R4 above window", 16'(d), 16'h0);
    rd(1, d, v); check("R5 advance while gated", 16'(d), 16'h0);
    wreg(1, 2, 8'h00);
    rd(1, d, v); check("R5 pointer kept stepping", 16'(d), 16'(img(16'h1242)));
  endtask

  task automatic t_wrap();
    logic [7:0] d; logic v;
    setup(2, 16'hFFFF, 8'h00, 8'h00);
    rd(2, d, v); check("R5 at FFFF", 16'(d), 16'(img(16'hFFFF)));
    rd(2, d, v); check("R5 wrap to 0000", 16'(d), 16'(img(16'h0000)));
  endtask

  task automatic t_indep();
    logic [7:0] d; logic v;
    setup(3, 16'h0500, 8'h00, 8'h00);
    setup(5, 16'h0A00, 8'h00, 8'h00);
    rd(3, d, v); rd(3, d, v);
    check("R6 fetcher 3 second", 16'(d), 16'(img(16'h0501)));
    rd(5, d, v); check("R6 fetcher 5 untouched", 16'(d), 16'(img(16'h0A00)));
    rd(3, d, v); check("R6 fetcher 3 third", 16'(d), 16'(img(16'h0502)));
  endtask

  task automatic t_mem_port();
    setup(7, 16'hBEEF, 8'h00, 8'h00);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 3'd7;
    #1;
    check("R7 mem_en", 16'(mem_en), 16'h1);
    check("R7 mem_addr", mem_addr, 16'hBEEF);
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    check("R7 mem_en idle", 16'(mem_en), 16'h0);
  endtask

  task automatic t_ptr_collide();
    logic [7:0] d; logic v;
    setup(0, 16'h0340, 8'h00, 8'h00);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 3'd0; wr_en = 1'b1; wr_addr = AW'(0); wr_data = 8'h80;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R8 read uses old pointer", 16'(rd_data), 16'(img(16'h0340)));
    rd(0, d, v); check("R8 write wins over increment", 16'(d), 16'(img(16'h0380)));
  endtask

  task automatic t_mask_collide();
    logic [7:0] d; logic v;
    setup(4, 16'h0010, 8'h00, 8'h00);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 3'd4; wr_en = 1'b1; wr_addr = AW'(4 * 4 + 2); wr_data = 8'hFF;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R9 old window used", 16'(rd_data), 16'(img(16'h0010)));
    rd(4, d, v); check("R9 new mask governs", 16'(d), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_wrap();
    t_indep();
    t_mem_port();
    t_ptr_collide();
    t_mask_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule